// File: doc/BRIEF.md
# Control-Bus Byte-Link Master

This block bridges one register transaction at a time from a simple on-chip control port to a remote register slave over a narrow half-duplex byte link. A caller pulses a write or read strobe with a 20-bit address (and 32-bit data for writes). The block packs the request into a short frame and sends it one byte per cycle. It then hands the link to the remote side by raising a direction line, collects the answer and returns one acknowledge with a 2-bit status and read data.

The link is owned by the master. The direction line is low while the master talks and high while the slave answers. Pulling it low again ends the turn and also aborts a slave that is still waiting or answering. A request carries only the low 15 address bits, with a write flag in the most significant bit of the first byte. The answer ends in a status byte whose bit 2 marks it as genuine. When no complete answer arrives within a parameterised number of cycles, the master takes the link back and reports an error. A status byte without its marker bit is reported the same way.

Top module: `cbl_link_master`

## Requirements
- R1: A read request is exactly 2 bytes. Byte 0 has bit 7 = 0 and bits 6:0 = addr[14:8]. Byte 1 = addr[7:0]. Address bits 19:15 are not sent.
- R2: A write request is exactly 6 bytes. Byte 0 has bit 7 = 1 and bits 6:0 = addr[14:8]. Byte 1 = addr[7:0]. Bytes 2..5 carry the write data, most significant byte first.
- R3: link_vout is high on consecutive cycles, exactly once per request byte, starting the cycle after the strobe is accepted. link_dir stays low throughout.
- R4: link_dir goes high in the first cycle after the last request byte. It stays high until the response completes or the timeout fires.
- R5: A read response is 5 bytes: the read data most significant byte first, then a status byte. If status bit 2 is 1, the acknowledge carries status = status byte bits 1:0 and the received data.
- R6: A write response is one status byte. If its bit 2 is 1, the acknowledge carries status = bits 1:0 and read data zero.
- R7: A status byte with bit 2 = 0 produces an acknowledge with status 2'b11 and read data zero.
- R8: If the full response has not been sampled by the TIMEOUT_CYCLES-th cycle with link_dir high, link_dir drops at that edge. At the same edge an acknowledge with status 2'b11 and data zero is given.
- R9: Each accepted request yields exactly one resp_ack pulse, one cycle wide. On a normal response it comes in the cycle after the final response byte is sampled.
- R10: Strobes are accepted only when idle, so strobes during a transaction start no frame. When req_wr and req_rd are both high, the request is a write.
- R11: After link_dir falls, at least TURN_GAP cycles pass with link_dir and link_vout both low before the next request byte.
- R12: During and right after reset, link_dir, link_vout and resp_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Read request strobe |
| req_addr | input | 20 | Register address (low 15 bits carried) |
| req_wdata | input | 32 | Write data |
| resp_ack | output | 1 | One-cycle acknowledge |
| resp_status | output | 2 | Response status (2'b11 = link error) |
| resp_rdata | output | 32 | Read data, zero for writes and errors |
| link_dout | output | 8 | Request byte to the link |
| link_vout | output | 1 | Request byte valid |
| link_dir | output | 1 | Link direction: 0 master sends, 1 slave answers |
| link_din | input | 8 | Response byte from the link |
| link_vin | input | 1 | Response byte valid |

## Verification
The hardest situations to reach are those where the remote side misbehaves rather than answers. These are a slave that never answers, one that stops after part of a read response, and one whose status byte lacks its marker. The bench's responder model is steered per transaction to send full, partial or no answers, with delays and gaps between bytes. For the timeout cases it measures how many cycles the direction line stayed high. Strobes are also held high through the send and wait phases, so that a wrongly accepted request would show up as extra link bytes or a surplus acknowledge.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  typedef enum logic [1:0] {
    ST_GAP  = 2'd0,
    ST_IDLE = 2'd1,
    ST_SEND = 2'd2,
    ST_RESP = 2'd3
  } cbl_state_e;

  localparam int REQ_MAX_BYTES = 6;
  localparam int RSP_MAX_BYTES = 5;
  localparam logic [1:0] STS_ERR = 2'b11;

  typedef struct packed {
    logic [1:0]  status;
    logic [31:0] data;
  } cbl_resp_t;

  // Left-justified request frame: top byte leaves first.
  function automatic logic [REQ_MAX_BYTES*8-1:0] pack_request(
    input logic wr, input logic [19:0] addr, input logic [31:0] wdata);
    logic [REQ_MAX_BYTES*8-1:0] f;
    f = {wr, addr[14:0], 32'h0};
    if (wr) f[31:0] = wdata;
    return f;
  endfunction

  function automatic logic [2:0] req_bytes(input logic wr);
    return wr ? 3'd6 : 3'd2;
  endfunction

  function automatic logic [2:0] rsp_bytes(input logic wr);
    return wr ? 3'd1 : 3'd5;
  endfunction

  // body: previously gathered data bytes; sbyte: the trailing status byte
  function automatic cbl_resp_t decode_response(
    input logic wr, input logic [31:0] body, input logic [7:0] sbyte);
    cbl_resp_t r;
    if (!sbyte[2]) begin
      r.status = STS_ERR;
      r.data   = 32'h0;
    end else begin
      r.status = sbyte[1:0];
      r.data   = wr ? 32'h0 : body;
    end
    return r;
  endfunction

endpackage

// File: rtl/cbl_tx_shift.sv
module cbl_tx_shift #(
  parameter int NBYTES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NBYTES*8-1:0] frame,
  input  logic              shift,
  output logic [7:0]        dout
);
  logic [NBYTES*8-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= frame;
    else if (shift) sh_q <= {sh_q[NBYTES*8-9:0], 8'h00};
  end

  assign dout = sh_q[NBYTES*8-1 -: 8];

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/cbl_rx_gather.sv
module cbl_rx_gather #(
  parameter int NBYTES = 4,
  localparam int CW = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                take,
  input  logic [7:0]          din,
  output logic [CW-1:0]       count,
  output logic [NBYTES*8-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      data  <= '0;
    end else if (take) begin
      count <= count + 1'b1;
      data  <= {data[NBYTES*8-9:0], din};
    end
  end

  // R5
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(NBYTES));
endmodule

// File: rtl/cbl_timeout.sv
module cbl_timeout #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  // R8
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TW'(LIMIT - 1));
endmodule

// File: rtl/cbl_link_master.sv
module cbl_link_master
  import cbl_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int TURN_GAP       = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_wr,
  input  logic        req_rd,
  input  logic [19:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        resp_ack,
  output logic [1:0]  resp_status,
  output logic [31:0] resp_rdata,
  output logic [7:0]  link_dout,
  output logic        link_vout,
  output logic        link_dir,
  input  logic [7:0]  link_din,
  input  logic        link_vin
);
  localparam int BODY_BYTES = RSP_MAX_BYTES - 1;
  localparam int CW = $clog2(BODY_BYTES + 1);
  localparam int GW = $clog2(TURN_GAP + 1);
  localparam int QW = GW + 1;

  cbl_state_e     state_q;
  logic           is_wr_q;
  logic [2:0]     tx_idx_q;
  logic [GW-1:0]  gap_q;

  logic               accept, tx_last, rx_take, rx_last, rx_store, wd_expired;
  logic [7:0]         tx_byte;
  logic [CW-1:0]      rx_cnt;
  logic [BODY_BYTES*8-1:0] rx_body;
  cbl_resp_t          fin;

  assign accept   = (state_q == ST_IDLE) && (req_wr || req_rd);
  assign tx_last  = (state_q == ST_SEND) && (tx_idx_q == req_bytes(is_wr_q) - 3'd1);
  assign rx_take  = (state_q == ST_RESP) && link_vin;
  assign rx_last  = rx_take && (rx_cnt == CW'(rsp_bytes(is_wr_q) - 3'd1));
  assign rx_store = rx_take && !rx_last;
  assign fin      = decode_response(is_wr_q, rx_body[31:0], link_din);

  cbl_tx_shift #(.NBYTES(REQ_MAX_BYTES)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .frame (pack_request(req_wr, req_addr, req_wdata)),
    .shift (state_q == ST_SEND),
    .dout  (tx_byte)
  );

  cbl_rx_gather #(.NBYTES(BODY_BYTES)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .take  (rx_store),
    .din   (link_din),
    .count (rx_cnt),
    .data  (rx_body)
  );

  cbl_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_RESP),
    .expired (wd_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_GAP;
      is_wr_q     <= 1'b0;
      tx_idx_q    <= 3'd0;
      gap_q       <= '0;
      link_dir    <= 1'b0;
      resp_ack    <= 1'b0;
      resp_status <= 2'b00;
      resp_rdata  <= 32'h0;
    end else begin
      resp_ack <= 1'b0;
      case (state_q)
        ST_GAP: begin
          if (gap_q == GW'(TURN_GAP - 1)) begin
            gap_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            is_wr_q  <= req_wr;
            tx_idx_q <= 3'd0;
            state_q  <= ST_SEND;
          end
        end
        ST_SEND: begin
          tx_idx_q <= tx_idx_q + 3'd1;
          if (tx_last) begin
            link_dir <= 1'b1;
            state_q  <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rx_last) begin
            resp_ack    <= 1'b1;
            resp_status <= fin.status;
            resp_rdata  <= fin.data;
            link_dir    <= 1'b0;
            state_q     <= ST_GAP;
          end else if (wd_expired) begin
            resp_ack    <= 1'b1;
            resp_status <= STS_ERR;
            resp_rdata  <= 32'h0;
            link_dir    <= 1'b0;
            state_q     <= ST_GAP;
          end
        end
        default: state_q <= ST_GAP;
      endcase
    end
  end

  assign link_vout = (state_q == ST_SEND);
  assign link_dout = link_vout ? tx_byte : 8'h00;

  // Quiet-cycle counter used only by the turnaround check
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk) begin
    if (rst || link_dir || link_vout) quiet_q <= '0;
    else if (quiet_q != {QW{1'b1}})   quiet_q <= quiet_q + 1'b1;
  end

  // R3
  vout_dir_low_chk: assert property (@(posedge clk) disable iff (rst)
    link_vout |-> !link_dir);
  // R4
  turn_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(link_vout) |-> link_dir);
  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    resp_ack |=> !resp_ack);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESP || state_q == ST_GAP) |=> (state_q != ST_SEND));
  // R11
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_vout) |-> (quiet_q >= QW'(TURN_GAP)));
  // R5
  status_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_last && link_din[2]) |=> (resp_ack && resp_status == $past(link_din[1:0])));
  // R7
  marker_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_last && !link_din[2]) |=> (resp_ack && resp_status == STS_ERR && resp_rdata == 32'h0));
  // R8
  timeout_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_expired && !rx_last) |=> (resp_ack && resp_status == STS_ERR && !link_dir));
endmodule

// File: tb/cbl_link_master_tb.sv
`timescale 1ns/1ps
module cbl_link_master_tb;
  localparam int TO  = 64;
  localparam int GAP = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_wr = 1'b0, req_rd = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_ack;
  logic [1:0]  resp_status;
  logic [31:0] resp_rdata;
  logic [7:0]  link_dout;
  logic        link_vout, link_dir;
  logic [7:0]  link_din = '0;
  logic        link_vin = 1'b0;

  cbl_link_master #(.TIMEOUT_CYCLES(TO), .TURN_GAP(GAP)) u_dut (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_ack(resp_ack),
    .resp_status(resp_status), .resp_rdata(resp_rdata), .link_dout(link_dout),
    .link_vout(link_vout), .link_dir(link_dir), .link_din(link_din), .link_vin(link_vin));

  int total = 0, bad = 0;
  logic [7:0]  exp_b[$];
  logic [1:0]  exp_s[$];
  logic [31:0] exp_d[$];
  string byte_tag = "R1", ack_tag = "R5";
  int frame_len_exp = 0, frame_cnt = 0, quiet = 0;
  int hi_run = 0, last_hi_run = 0, ack_cnt = 0;
  logic prev_vout = 1'b0;
  logic [7:0] eb;
  logic [1:0] es_pop;
  logic [31:0] ed_pop;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: link bytes, turnaround and acknowledges
  always @(negedge clk) if (!rst) begin
    if (link_dir) hi_run++;
    else if (hi_run != 0) begin last_hi_run = hi_run; hi_run = 0; end
    if (link_vout && !prev_vout) chk(quiet >= GAP, "R11", "quiet cycles", quiet, GAP);
    if (link_vout || link_dir) quiet = 0; else quiet++;
    if (link_vout) begin
      chk(!link_dir, "R3", "dir during request", {31'h0, link_dir}, 0);
      if (exp_b.size() == 0) chk(1'b0, "R10", "unexpected request byte", {24'h0, link_dout}, 0);
      else begin
        eb = exp_b.pop_front();
        chk(link_dout == eb, byte_tag, "request byte", {24'h0, link_dout}, {24'h0, eb});
      end
      frame_cnt++;
    end else if (prev_vout) begin
      chk(link_dir, "R4", "dir after last byte", {31'h0, link_dir}, 1);
      chk(frame_cnt == frame_len_exp, "R3", "frame length", frame_cnt, frame_len_exp);
      frame_cnt = 0;
    end
    prev_vout = link_vout;
    if (resp_ack) begin
      ack_cnt++;
      if (exp_s.size() == 0) chk(1'b0, "R9", "unexpected ack", 1, 0);
      else begin
        es_pop = exp_s.pop_front();
        ed_pop = exp_d.pop_front();
        chk(resp_status == es_pop, ack_tag, "ack status", {30'h0, resp_status}, {30'h0, es_pop});
        chk(resp_rdata == ed_pop, ack_tag, "ack data", resp_rdata, ed_pop);
      end
    end
  end

  // Driver: mode 0 full answer, 1 no answer, 2 partial answer
  task automatic run_txn(input bit wr, input bit rd, input logic [19:0] addr,
                         input logic [31:0] wd, input int mode, input int delay,
                         input bit vgap, input logic [7:0] sbyte, input logic [31:0] rdata,
                         input logic [1:0] es, input logic [31:0] ed,
                         input string btag, input string atag, input bit busy);
    bit iswr;
    int n0;
    logic [7:0] rsp[$];
    iswr = wr;
    exp_b.push_back({iswr, addr[14:8]});
    exp_b.push_back(addr[7:0]);
    if (iswr) for (int i = 3; i >= 0; i--) exp_b.push_back(wd[i*8 +: 8]);
    frame_len_exp = iswr ? 6 : 2;
    byte_tag = btag;
    ack_tag  = atag;
    exp_s.push_back(es);
    exp_d.push_back(ed);
    n0 = ack_cnt;
    @(negedge clk);
    req_wr = wr; req_rd = rd; req_addr = addr; req_wdata = wd;
    do @(negedge clk); while (!link_vout);
    req_wr = 1'b0; req_rd = busy;
    do @(negedge clk); while (!link_dir);
    if (!iswr) for (int i = 3; i >= 0; i--) rsp.push_back(rdata[i*8 +: 8]);
    rsp.push_back(sbyte);
    if (mode == 1) rsp.delete();
    if (mode == 2) while (rsp.size() > 2) void'(rsp.pop_back());
    repeat (delay) @(negedge clk);
    req_rd = 1'b0;
    foreach (rsp[i]) begin
      link_din = rsp[i]; link_vin = 1'b1;
      @(negedge clk);
      if (vgap) begin link_vin = 1'b0; @(negedge clk); end
    end
    link_vin = 1'b0; link_din = 8'h00;
    while (ack_cnt == n0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit quiet_ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!link_dir && !link_vout && !resp_ack, "R12", "outputs in reset",
        {29'h0, link_dir, link_vout, resp_ack}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!link_dir && !link_vout && !resp_ack, "R12", "outputs after reset",
        {29'h0, link_dir, link_vout, resp_ack}, 0);

    // R1 R5: read with high address bits set, good marker
    run_txn(0, 1, 20'h7A5C3, 32'h0, 0, 0, 0, 8'h05, 32'hDEADBEEF, 2'b01, 32'hDEADBEEF, "R1", "R5", 0);
    // R2 R6: write, status 10
    run_txn(1, 0, 20'h00123, 32'h01234567, 0, 2, 0, 8'h06, 32'h0, 2'b10, 32'h0, "R2", "R6", 0);
    // R5: read with delay and gaps between response bytes
    run_txn(0, 1, 20'h07FFF, 32'h0, 0, 3, 1, 8'h04, 32'h80000001, 2'b00, 32'h80000001, "R1", "R5", 0);
    // R7: read, marker clear
    run_txn(0, 1, 20'h00042, 32'h0, 0, 1, 0, 8'h03, 32'hCAFEF00D, 2'b11, 32'h0, "R1", "R7", 0);
    // R7: write, marker clear with upper bits set
    run_txn(1, 0, 20'h01000, 32'hA5A5A5A5, 0, 0, 0, 8'hF8, 32'h0, 2'b11, 32'h0, "R2", "R7", 0);
    // R8: no answer
    run_txn(0, 1, 20'h00010, 32'h0, 1, 0, 0, 8'h04, 32'h0, 2'b11, 32'h0, "R1", "R8", 0);
    chk(last_hi_run == TO, "R8", "dir high cycles before abort", last_hi_run, TO);
    // R8: partial read answer
    run_txn(0, 1, 20'h00020, 32'h0, 2, 0, 0, 8'h04, 32'h11223344, 2'b11, 32'h0, "R1", "R8", 0);
    chk(last_hi_run == TO, "R8", "dir high cycles after partial", last_hi_run, TO);
    // R10: both strobes -> write
    run_txn(1, 1, 20'h02A55, 32'hFEDCBA98, 0, 0, 0, 8'h07, 32'h0, 2'b11, 32'h0, "R10", "R6", 0);
    // R10: read strobe held through send and wait phases
    run_txn(0, 1, 20'h00333, 32'h0, 0, 6, 0, 8'h05, 32'h55AA55AA, 2'b01, 32'h55AA55AA, "R1", "R5", 1);
    quiet_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (link_vout) quiet_ok = 1'b0;
    end
    chk(quiet_ok, "R10", "no frame after busy strobes", {31'h0, !quiet_ok}, 0);
    chk(exp_b.size() == 0, "R9", "request bytes left", exp_b.size(), 0);
    chk(exp_s.size() == 0 && ack_cnt == 9, "R9", "acknowledge count", ack_cnt, 9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule